// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one timer channel for a peripheral subsystem. A 32-bit counter steps down by one on every prescaled tick of the peripheral clock. When a tick finds the counter at zero, the counter is refilled from a reload constant and a sticky underflow flag is raised. That flag, together with an interrupt-enable bit, drives a level interrupt line.

Software reaches the channel through four word registers: reload constant, live counter, control and capture. It writes them with a single-cycle write strobe and reads them through a combinational read port. An external `run_en` input starts and stops counting. Control writes that carry an illegal or reserved encoding are stored with the offending field cleared, and a one-cycle error strobe reports them.

Top module: `reload_timer_channel`

## Requirements
- R1: Address bits [3:2] pick the register: 0 reload constant, 1 counter, 2 control, 3 capture. Address bits [1:0] are ignored.
- R2: After reset the reload constant and the counter read 0xFFFFFFFF, and the control register reads 0.
- R3: Control code [2:0] values 0 to 4 give one tick every 4, 16, 64, 256 or 1024 clocks, counted only while `run_en` is 1. The divider holds while `run_en` is 0. A control write that changes the code restarts the divider from zero.
- R4: Each tick lowers a nonzero counter by one. A counter write loads the value at once and wins over a tick in the same cycle. The next tick counts down from the written value.
- R5: A tick with the counter at zero reloads it from the reload constant and sets the underflow flag. No tick, and so no reload and no flag, happens while `run_en` is 0.
- R6: Control bit 8 reads the underflow flag. Writing 0 to it clears the flag and writing 1 leaves it unchanged, so software can never set it. An underflow in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is 1 exactly while the underflow flag and control bit 5 (interrupt enable) are both 1.
- R8: Each illegal control field is stored as zero, while the other fields keep their written value. The illegal cases are: code 5; codes 6 and 7 without external-clock support; a nonzero edge field [4:3] without external-clock support; capture mode [7:6] equal to 1, or 2 and 3 without the capture feature; bit 9 written 1 without the capture feature; and any nonzero bit in [31:10]. Bit 9 always reads 0. `err_o` is 1 for exactly the cycle after such a write.
- R9: With the capture feature, register 3 is plain read/write storage. Without it, a read or write of register 3 reads 0, stores nothing and pulses `err_o` in the following cycle.
- R10: Writing the reload constant does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Level interrupt |
| err_o | output | 1 | One-cycle strobe for an illegal access |

## Verification
The bench lands a counter write on the very clock edge where a tick falls due. A design that let the tick win would read one below the written value. It also clears the flag on the edge where an underflow occurs; a design that let the clear win would lose the interrupt. It changes the prescale code while the divider is part-way through a period; without the restart, the next tick would arrive hundreds of clocks late or never. Finally, it writes control words that mix legal and illegal fields. A design that rejected the whole word, or kept the bad field, would read back the wrong control value.

// File: rtl/rtc_pkg.sv
// Package: shared constants, control field layout and prescale lookup for the
// reloading timer channel. Assumes a 32-bit register bus.
package rtc_pkg;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 10;

    typedef enum logic [1:0] {
        IDX_RELOAD = 2'd0,
        IDX_COUNT  = 2'd1,
        IDX_CTRL   = 2'd2,
        IDX_CAPT   = 2'd3
    } reg_idx_e;

    // Stored control fields; packed order matches bits [7:0] of the register.
    typedef struct packed {
        logic [1:0] capmode;
        logic       ie;
        logic [1:0] edge_sel;
        logic [2:0] psc;
    } ctrl_t;

    localparam int FLAG_BIT = 8;
    localparam int CAPF_BIT = 9;
    localparam int RSV_LSB  = 10;

    // Terminal divider value for a prescale code (ratio minus one).
    function automatic logic [DIV_W-1:0] div_last(input logic [2:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            3'd0:    r = DIV_W'(3);
            3'd1:    r = DIV_W'(15);
            3'd2:    r = DIV_W'(63);
            3'd3:    r = DIV_W'(255);
            3'd4:    r = DIV_W'(1023);
            default: r = '0;
        endcase
        return r;
    endfunction

    // True when the code selects an internal prescale ratio.
    function automatic logic psc_internal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: divides the clock by the ratio the code selects and emits a
// one-cycle tick. Assumes codes above 4 (external clock) produce no tick.
module tmr_prescaler
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic             active;

    // Tick when the divider reaches the terminal value of the current code.
    always_comb begin
        active = run_en && psc_internal(code);
        tick   = active && (div_q == div_last(code));
    end

    // Divider: restart on code change, hold while stopped, wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (active) begin
            div_q <= tick ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_ctrl_reg.sv
// Control register: cleans each written field and reports illegal ones. Also
// holds the sticky underflow flag. Assumes the write data is at least 16 bits wide.
module tmr_ctrl_reg
    import rtc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit HAS_EXTCLK  = 1'b0,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              underflow,
    output ctrl_t             ctrl_q,
    output logic              flag_q,
    output logic              bad_wr,
    output logic              code_change
);
    ctrl_t clean;
    logic  bad;

    // Clear each illegal field on its own and note that something was bad.
    always_comb begin
        clean = ctrl_t'(wdata[7:0]);
        bad   = 1'b0;
        if (clean.psc == 3'd5 || (clean.psc >= 3'd6 && !HAS_EXTCLK)) begin
            clean.psc = 3'd0;
            bad       = 1'b1;
        end
        if (clean.edge_sel != 2'd0 && !HAS_EXTCLK) begin
            clean.edge_sel = 2'd0;
            bad            = 1'b1;
        end
        if (clean.capmode == 2'd1 || (clean.capmode >= 2'd2 && !HAS_CAPTURE)) begin
            clean.capmode = 2'd0;
            bad           = 1'b1;
        end
        if (wdata[CAPF_BIT] && !HAS_CAPTURE) begin
            bad = 1'b1;
        end
        if (|wdata[DATA_W-1:RSV_LSB]) begin
            bad = 1'b1;
        end
        bad_wr      = wr && bad;
        code_change = wr && (clean.psc != ctrl_q.psc);
    end

    // Control fields take the cleaned value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q <= clean;
        end
    end

    // Underflow flag: set by hardware, cleared only by a written 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (underflow) begin
            flag_q <= 1'b1;
        end else if (wr && !wdata[FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
// Counter core: holds the reload constant and the down-counter and reloads
// on underflow. Assumes ticks are single-cycle pulses.
module tmr_count_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_wr,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              underflow
);
    // An underflow is a tick at zero that no counter write overrides.
    always_comb begin
        underflow = tick && !cnt_wr && (cnt_q == '0);
    end

    // Reload constant storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
        end else if (reload_wr) begin
            reload_q <= wdata;
        end
    end

    // Down-counter: a write wins, then reload on underflow, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (underflow) begin
            cnt_q <= reload_q;
        end else if (tick) begin
            cnt_q <= cnt_q - DATA_W'(1);
        end
    end
endmodule

// File: rtl/reload_timer_channel.sv
// Top: decodes register accesses, muxes read data, registers the error strobe
// and gates the interrupt. Assumes one access per cycle on the register bus.
module reload_timer_channel
    import rtc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit HAS_EXTCLK  = 1'b0,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              err_o
);
    reg_idx_e          idx;
    logic              reload_wr, cnt_wr, ctrl_wr, capt_wr, capt_bad;
    logic              tick, underflow, flag_q, bad_wr, code_change, err_q;
    logic [DATA_W-1:0] cnt_q, reload_q, capt_q, ctrl_rd;
    ctrl_t             ctrl_q;
    logic              unused_addr;

    // Register select and per-register write strobes.
    always_comb begin
        idx         = reg_idx_e'(bus_addr[3:2]);
        unused_addr = ^bus_addr[1:0];
        reload_wr   = bus_wr && idx == IDX_RELOAD;
        cnt_wr      = bus_wr && idx == IDX_COUNT;
        ctrl_wr     = bus_wr && idx == IDX_CTRL;
        capt_wr     = bus_wr && idx == IDX_CAPT;
        capt_bad    = !HAS_CAPTURE && (bus_wr || bus_rd) && idx == IDX_CAPT;
    end

    tmr_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .restart (code_change),
        .code    (ctrl_q.psc),
        .tick    (tick)
    );

    tmr_ctrl_reg #(
        .DATA_W      (DATA_W),
        .HAS_EXTCLK  (HAS_EXTCLK),
        .HAS_CAPTURE (HAS_CAPTURE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctrl_wr),
        .wdata       (bus_wdata),
        .underflow   (underflow),
        .ctrl_q      (ctrl_q),
        .flag_q      (flag_q),
        .bad_wr      (bad_wr),
        .code_change (code_change)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_wr (reload_wr),
        .cnt_wr    (cnt_wr),
        .wdata     (bus_wdata),
        .tick      (tick),
        .cnt_q     (cnt_q),
        .reload_q  (reload_q),
        .underflow (underflow)
    );

    // Capture storage exists only on channels built with the feature.
    generate
        if (HAS_CAPTURE) begin : g_capt
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    capt_q <= '0;
                end else if (capt_wr) begin
                    capt_q <= bus_wdata;
                end
            end
        end else begin : g_no_capt
            assign capt_q = '0;
        end
    endgenerate

    // Read mux; the control view merges the flag at its bit position.
    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[7:0]      = ctrl_q;
        ctrl_rd[FLAG_BIT] = flag_q;
        bus_rdata         = '0;
        if (bus_rd) begin
            case (idx)
                IDX_RELOAD: bus_rdata = reload_q;
                IDX_COUNT:  bus_rdata = cnt_q;
                IDX_CTRL:   bus_rdata = ctrl_rd;
                default:    bus_rdata = capt_q;
            endcase
        end
    end

    // Error strobe: one cycle after an illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad_wr || capt_bad;
        end
    end

    assign err_o = err_q;
    assign irq   = flag_q && ctrl_q.ie;
endmodule

// File: rtl/reload_timer_channel_chk.sv
// Checker: temporal properties of the timer channel, bound to every instance.
module reload_timer_channel_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [3:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              err_o,
    input logic              tick,
    input logic              cnt_wr,
    input logic              underflow,
    input logic              flag_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] reload_q
);
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1)); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(cnt_q)); // R5
    AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_q == $past(reload_q)) && flag_q); // R5
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd2 && !bus_wdata[8] && !underflow) |=> !irq); // R6
    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(bus_wr || bus_rd)); // R8
endmodule

bind reload_timer_channel reload_timer_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .err_o     (err_o),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .underflow (underflow),
    .flag_q    (flag_q),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q)
);

// File: tb/reload_timer_channel_test.sv
// Bench: table-driven register checks, then directed timing and corner tests.
module reload_timer_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, nc_rdata;
    logic        irq, nc_irq, err_o, nc_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic        wr_err, nc_wr_err, rd_err, nc_rd_err;
    logic [31:0] rd_val, nc_rd_val;

    always #4 clk = ~clk;

    reload_timer_channel uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .err_o(err_o)
    );

    reload_timer_channel #(.HAS_CAPTURE(1'b0)) uut_nocap (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(nc_rdata), .irq(nc_irq), .err_o(nc_err)
    );

    // Vector: {is_write, addr[3:0], wdata[31:0], expected read[31:0], expected err}
    localparam int NV = 27;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 4'h0, 32'h0, 32'hFFFF_FFFF, 1'b0},  // R2
        {1'b0, 4'h4, 32'h0, 32'hFFFF_FFFF, 1'b0},  // R2
        {1'b0, 4'h8, 32'h0, 32'h0000_0000, 1'b0},  // R2
        {1'b1, 4'h0, 32'h0000_1234, 32'h0, 1'b0},  // R1
        {1'b0, 4'h0, 32'h0, 32'h0000_1234, 1'b0},  // R1
        {1'b0, 4'h4, 32'h0, 32'hFFFF_FFFF, 1'b0},  // R10
        {1'b1, 4'h4, 32'h0000_0055, 32'h0, 1'b0},  // R4
        {1'b0, 4'h4, 32'h0, 32'h0000_0055, 1'b0},  // R4
        {1'b1, 4'h8, 32'h0000_0021, 32'h0, 1'b0},  // R8 legal
        {1'b0, 4'h8, 32'h0, 32'h0000_0021, 1'b0},
        {1'b1, 4'h8, 32'h0000_0425, 32'h0, 1'b1},  // R8 code 5 + reserved
        {1'b0, 4'h8, 32'h0, 32'h0000_0020, 1'b0},
        {1'b1, 4'h8, 32'h0000_0007, 32'h0, 1'b1},  // R8 code 7, no ext clock
        {1'b0, 4'h8, 32'h0, 32'h0000_0000, 1'b0},
        {1'b1, 4'h8, 32'h0000_0018, 32'h0, 1'b1},  // R8 edge field
        {1'b0, 4'h8, 32'h0, 32'h0000_0000, 1'b0},
        {1'b1, 4'h8, 32'h0000_00C3, 32'h0, 1'b0},  // R8 capture mode 3 legal
        {1'b0, 4'h8, 32'h0, 32'h0000_00C3, 1'b0},
        {1'b1, 4'h8, 32'h0000_0040, 32'h0, 1'b1},  // R8 capture mode 1
        {1'b0, 4'h8, 32'h0, 32'h0000_0000, 1'b0},
        {1'b1, 4'h8, 32'h0000_0204, 32'h0, 1'b0},  // R8 bit 9 reads 0
        {1'b0, 4'h8, 32'h0, 32'h0000_0004, 1'b0},
        {1'b1, 4'hC, 32'h0000_ABCD, 32'h0, 1'b0},  // R9
        {1'b0, 4'hC, 32'h0, 32'h0000_ABCD, 1'b0},  // R9
        {1'b1, 4'h8, 32'h0000_0100, 32'h0, 1'b0},  // R6 software cannot set
        {1'b0, 4'h8, 32'h0, 32'h0000_0000, 1'b0},  // R6
        {1'b0, 4'h2, 32'h0, 32'h0000_1234, 1'b0}   // R1 low bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        wr_err = err_o; nc_wr_err = nc_err;
    endtask

    task automatic do_rd(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        rd_val = bus_rdata; nc_rd_val = nc_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_err = err_o; nc_rd_err = nc_err;
    endtask

    task automatic run_edges(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        do_reset();
        check("R2 irq at reset", {31'b0, irq}, 32'h0);
        check("R2 err at reset", {31'b0, err_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][69]) begin
                do_wr(VEC[i][68:65], VEC[i][64:33]);
                check($sformatf("R8 vec %0d err", i), {31'b0, wr_err}, {31'b0, VEC[i][0]});
            end else begin
                do_rd(VEC[i][68:65]);
                check($sformatf("R1 vec %0d read", i), rd_val, VEC[i][32:1]);
                check($sformatf("R9 vec %0d err", i), {31'b0, rd_err}, {31'b0, VEC[i][0]});
            end
        end

        // A: code 0 countdown, underflow, flag and interrupt gating
        do_reset();
        do_wr(4'h0, 32'd5);
        do_wr(4'h4, 32'd2);
        do_wr(4'h8, 32'h20);
        run_edges(4);
        do_rd(4'h4); check("R3 code0 one tick", rd_val, 32'd1);
        run_edges(8);
        do_rd(4'h4); check("R5 reload on underflow", rd_val, 32'd5);
        do_rd(4'h8); check("R6 flag readback", rd_val, 32'h120);
        check("R7 irq with flag and enable", {31'b0, irq}, 32'h1);
        do_wr(4'h0, 32'd9);
        do_rd(4'h4); check("R10 reload write keeps counter", rd_val, 32'd5);
        do_wr(4'h8, 32'h120);
        check("R6 writing 1 keeps flag", {31'b0, irq}, 32'h1);
        do_wr(4'h8, 32'h100);
        check("R7 irq off when disabled", {31'b0, irq}, 32'h0);
        do_rd(4'h8); check("R7 flag still set", rd_val, 32'h100);
        do_wr(4'h8, 32'h020);
        do_rd(4'h8); check("R6 writing 0 clears", rd_val, 32'h20);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);
        repeat (20) @(posedge clk);
        do_rd(4'h4); check("R5 no count while stopped", rd_val, 32'd5);

        // B: code 1 ratio and divider restart on code change
        do_wr(4'h8, 32'h01);
        do_wr(4'h4, 32'd10);
        run_edges(32);
        do_rd(4'h4); check("R3 code1 divide by 16", rd_val, 32'd8);
        run_edges(10);
        do_wr(4'h8, 32'h00);
        run_edges(4);
        do_rd(4'h4); check("R3 restart on code change", rd_val, 32'd7);

        // C: code 4
        do_wr(4'h8, 32'h04);
        do_wr(4'h4, 32'd100);
        run_edges(2048);
        do_rd(4'h4); check("R3 code4 divide by 1024", rd_val, 32'd98);

        // D: counter write on the tick edge wins
        do_wr(4'h8, 32'h00);
        do_wr(4'h4, 32'd50);
        @(negedge clk); run_en = 1'b1;
        repeat (3) @(posedge clk);
        do_wr(4'h4, 32'd20);
        run_en = 1'b0;
        do_rd(4'h4); check("R4 write beats tick", rd_val, 32'd20);
        run_edges(4);
        do_rd(4'h4); check("R4 counts from written value", rd_val, 32'd19);

        // E: underflow and clearing write in the same cycle
        do_wr(4'h4, 32'd0);
        do_wr(4'h8, 32'h20);
        @(negedge clk); run_en = 1'b1;
        repeat (3) @(posedge clk);
        do_wr(4'h8, 32'h20);
        run_en = 1'b0;
        do_rd(4'h8); check("R6 underflow beats clear", rd_val, 32'h120);
        do_rd(4'h4); check("R5 reload value", rd_val, 32'd9);
        check("R7 irq after collision", {31'b0, irq}, 32'h1);

        // F: capture register absent
        do_wr(4'hC, 32'h1111);
        check("R9 no-capture write err", {31'b0, nc_wr_err}, 32'h1);
        check("R9 capture write no err", {31'b0, wr_err}, 32'h0);
        do_rd(4'hC);
        check("R9 no-capture read zero", nc_rd_val, 32'h0);
        check("R9 no-capture read err", {31'b0, nc_rd_err}, 32'h1);
        check("R9 capture read data", rd_val, 32'h1111);
        do_rd(4'h0);
        check("R8 err lasts one cycle", {31'b0, nc_rd_err}, 32'h0);

        finish_run();
    end
endmodule